// File: doc/BRIEF.md
# SD Host Error Detail Capture

This block holds the detailed error word of an SD card host controller. The command-path and data-path engines report each fault as a one-cycle event pulse. A response-related pulse comes with a tag that says whether it belongs to the stop command (CMD12), which the host issues by itself once the programmed block count has been transferred, or to an ordinary command. Each event sets its own sticky bit in a 32-bit status word that software can read. The word keeps its contents until software writes the command register to start a new command.

From that word the block also drives five summary flags for the main interrupt status register. These are data timeout, command timeout, CRC, end bit and command index, and each is the OR of its group of detail bits.

A parameter removes the bits that belong only to the auto-issued stop command. Hosts without automatic stop commands use that build.

Top module: `sderr_capture`

## Requirements
- R1: `err_status` bit 13 reads 1 at all times. Bits 31-23, 19-18, 15-14, 12, 7 and 6 read 0 at all times.
- R2: While `rst_n` is low, and in the first cycle after it rises, `err_status` equals 32'h0000_2000 and all five summary flags are 0.
- R3: An event sampled at a rising clock edge becomes visible in `err_status` right after that edge. The data events map as follows: `ev_busy_tmo` sets bit 22, `ev_crcstat_tmo` sets bit 21 and `ev_start_tmo` sets bit 20.
- R4: `ev_rsp_tmo` sets bit 17 when `rsp_auto` is 1 and bit 16 when `rsp_auto` is 0. It never sets both.
- R5: The CRC events map as follows: `ev_wstat_crc` sets bit 11 and `ev_rdata_crc` sets bit 10. `ev_rsp_crc` sets bit 9 when `rsp_auto` is 1 and bit 8 when it is 0.
- R6: The end-bit events map as follows: `ev_wstat_end` sets bit 5 and `ev_rdata_end` sets bit 4. `ev_rsp_end` sets bit 3 when `rsp_auto` is 1 and bit 2 when it is 0.
- R7: `ev_rsp_idx` sets bit 1 when `rsp_auto` is 1 and bit 0 when it is 0.
- R8: A set error bit stays set through any number of cycles until `cmd_wr` is sampled high.
- R9: `cmd_wr` sampled high clears every error bit. Bit 13 stays 1.
- R10: When `cmd_wr` and an event are sampled at the same edge, the clear takes effect first and the event's bit ends up set.
- R11: The summary flags are ORs of status bits, with no extra delay: `flag_dat_tmo` = OR of bits 22..20, `flag_cmd_tmo` = OR of bits 17..16, `flag_crc` = OR of bits 11..8, `flag_endbit` = OR of bits 5..2 and `flag_index` = OR of bits 1..0.
- R12: With `AUTO_STOP` = 0, bits 17, 9, 3 and 1 always read 0. A response event tagged `rsp_auto` = 1 sets no bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Command register write strobe; clears the error bits |
| rsp_auto | input | 1 | Tag: the current response events belong to the auto-issued stop command |
| ev_busy_tmo | input | 1 | Timeout on busy after the CRC status |
| ev_crcstat_tmo | input | 1 | Timeout waiting for the write CRC status token |
| ev_start_tmo | input | 1 | Timeout waiting for the data start bit or for post-data busy |
| ev_rsp_tmo | input | 1 | Response timeout |
| ev_wstat_crc | input | 1 | CRC error in the write CRC status |
| ev_rdata_crc | input | 1 | CRC error in read data |
| ev_rsp_crc | input | 1 | CRC error in a response |
| ev_wstat_end | input | 1 | End-bit error in the write CRC status |
| ev_rdata_end | input | 1 | End-bit error in read data |
| ev_rsp_end | input | 1 | End-bit error in a response |
| ev_rsp_idx | input | 1 | Wrong command index in a response |
| err_status | output | 32 | Detailed error status word |
| flag_dat_tmo | output | 1 | Summary: data timeout |
| flag_cmd_tmo | output | 1 | Summary: command timeout |
| flag_crc | output | 1 | Summary: CRC error |
| flag_endbit | output | 1 | Summary: end-bit error |
| flag_index | output | 1 | Summary: command index error |

## Verification
The block's only internal state is the set of sticky error flops, so `err_status` shows that state directly. A lost, misrouted or stuck bit therefore shows up in the status word at the next sample after the edge that should have changed it, and in the matching summary flag in the same cycle. The checks that compare every cycle against a bench model cover four kinds of fault: a wrong auto/ordinary route, a clear that drops a coincident event, a bit that does not hold, and a reserved bit that leaks.

// File: rtl/sderr_pkg.sv
package sderr_pkg;

    localparam int STAT_W = 32;

    // Bit positions that software decodes.
    localparam int B_BUSY_TMO   = 22;
    localparam int B_CRCST_TMO  = 21;
    localparam int B_START_TMO  = 20;
    localparam int B_RSP_TMO_A  = 17;
    localparam int B_RSP_TMO    = 16;
    localparam int B_ONE        = 13;
    localparam int B_WST_CRC    = 11;
    localparam int B_RD_CRC     = 10;
    localparam int B_RSP_CRC_A  = 9;
    localparam int B_RSP_CRC    = 8;
    localparam int B_WST_END    = 5;
    localparam int B_RD_END     = 4;
    localparam int B_RSP_END_A  = 3;
    localparam int B_RSP_END    = 2;
    localparam int B_RSP_IDX_A  = 1;
    localparam int B_RSP_IDX    = 0;

    localparam logic [STAT_W-1:0] ONE_MASK  = STAT_W'(1) << B_ONE;
    localparam logic [STAT_W-1:0] AUTO_MASK = (STAT_W'(1) << B_RSP_TMO_A) |
                                              (STAT_W'(1) << B_RSP_CRC_A) |
                                              (STAT_W'(1) << B_RSP_END_A) |
                                              (STAT_W'(1) << B_RSP_IDX_A);
    localparam logic [STAT_W-1:0] ERR_MASK  = 32'h0073_0F3F;

    typedef struct packed {
        logic busy_tmo;
        logic crcstat_tmo;
        logic start_tmo;
        logic rsp_tmo;
        logic wstat_crc;
        logic rdata_crc;
        logic rsp_crc;
        logic wstat_end;
        logic rdata_end;
        logic rsp_end;
        logic rsp_idx;
    } sderr_ev_t;

endpackage

// File: rtl/sderr_route.sv
module sderr_route
    import sderr_pkg::*;
#(
    parameter bit AUTO_STOP = 1'b1
) (
    input  sderr_ev_t          ev,
    input  logic               rsp_auto,
    output logic [STAT_W-1:0]  set_vec
);
    logic [STAT_W-1:0] base_vec;
    logic [STAT_W-1:0] auto_vec;
    logic              use_auto;
    logic              use_plain;

    assign use_plain = ~rsp_auto;

    generate
        if (AUTO_STOP) begin : g_auto
            assign use_auto = rsp_auto;
        end else begin : g_noauto
            assign use_auto = 1'b0;
        end
    endgenerate

    always_comb begin
        base_vec = '0;
        base_vec[B_BUSY_TMO]  = ev.busy_tmo;
        base_vec[B_CRCST_TMO] = ev.crcstat_tmo;
        base_vec[B_START_TMO] = ev.start_tmo;
        base_vec[B_RSP_TMO]   = ev.rsp_tmo & use_plain;
        base_vec[B_WST_CRC]   = ev.wstat_crc;
        base_vec[B_RD_CRC]    = ev.rdata_crc;
        base_vec[B_RSP_CRC]   = ev.rsp_crc & use_plain;
        base_vec[B_WST_END]   = ev.wstat_end;
        base_vec[B_RD_END]    = ev.rdata_end;
        base_vec[B_RSP_END]   = ev.rsp_end & use_plain;
        base_vec[B_RSP_IDX]   = ev.rsp_idx & use_plain;
    end

    always_comb begin
        auto_vec = '0;
        auto_vec[B_RSP_TMO_A] = ev.rsp_tmo & use_auto;
        auto_vec[B_RSP_CRC_A] = ev.rsp_crc & use_auto;
        auto_vec[B_RSP_END_A] = ev.rsp_end & use_auto;
        auto_vec[B_RSP_IDX_A] = ev.rsp_idx & use_auto;
    end

    assign set_vec = base_vec | auto_vec;
endmodule

// File: rtl/sderr_sticky.sv
module sderr_sticky
    import sderr_pkg::*;
#(
    parameter logic [STAT_W-1:0] STORE_MASK = ERR_MASK,
    parameter logic [STAT_W-1:0] FIXED_ONE  = ONE_MASK
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic [STAT_W-1:0]  set_vec,
    output logic [STAT_W-1:0]  q
);
    for (genvar i = 0; i < STAT_W; i++) begin : g_bit
        if (STORE_MASK[i]) begin : g_flop
            logic r_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    r_q <= 1'b0;
                end else begin
                    r_q <= (r_q & ~clr) | set_vec[i];
                end
            end
            assign q[i] = r_q;
        end else begin : g_const
            assign q[i] = FIXED_ONE[i];
        end
    end
endmodule

// File: rtl/sderr_summary.sv
module sderr_summary
    import sderr_pkg::*;
(
    input  logic [STAT_W-1:0] stat,
    output logic              dat_tmo,
    output logic              cmd_tmo,
    output logic              crc,
    output logic              endbit,
    output logic              index
);
    assign dat_tmo = |stat[B_BUSY_TMO:B_START_TMO];
    assign cmd_tmo = |stat[B_RSP_TMO_A:B_RSP_TMO];
    assign crc     = |stat[B_WST_CRC:B_RSP_CRC];
    assign endbit  = |stat[B_WST_END:B_RSP_END];
    assign index   = |stat[B_RSP_IDX_A:B_RSP_IDX];
endmodule

// File: rtl/sderr_capture.sv
module sderr_capture
    import sderr_pkg::*;
#(
    parameter bit AUTO_STOP = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_wr,
    input  logic        rsp_auto,
    input  logic        ev_busy_tmo,
    input  logic        ev_crcstat_tmo,
    input  logic        ev_start_tmo,
    input  logic        ev_rsp_tmo,
    input  logic        ev_wstat_crc,
    input  logic        ev_rdata_crc,
    input  logic        ev_rsp_crc,
    input  logic        ev_wstat_end,
    input  logic        ev_rdata_end,
    input  logic        ev_rsp_end,
    input  logic        ev_rsp_idx,
    output logic [31:0] err_status,
    output logic        flag_dat_tmo,
    output logic        flag_cmd_tmo,
    output logic        flag_crc,
    output logic        flag_endbit,
    output logic        flag_index
);
    localparam logic [STAT_W-1:0] STORE = AUTO_STOP ? ERR_MASK : (ERR_MASK & ~AUTO_MASK);

    sderr_ev_t         ev;
    logic [STAT_W-1:0] set_vec;

    assign ev = '{busy_tmo:    ev_busy_tmo,
                  crcstat_tmo: ev_crcstat_tmo,
                  start_tmo:   ev_start_tmo,
                  rsp_tmo:     ev_rsp_tmo,
                  wstat_crc:   ev_wstat_crc,
                  rdata_crc:   ev_rdata_crc,
                  rsp_crc:     ev_rsp_crc,
                  wstat_end:   ev_wstat_end,
                  rdata_end:   ev_rdata_end,
                  rsp_end:     ev_rsp_end,
                  rsp_idx:     ev_rsp_idx};

    sderr_route #(.AUTO_STOP(AUTO_STOP)) u_route (
        .ev       (ev),
        .rsp_auto (rsp_auto),
        .set_vec  (set_vec)
    );

    sderr_sticky #(.STORE_MASK(STORE), .FIXED_ONE(ONE_MASK)) u_sticky (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (cmd_wr),
        .set_vec (set_vec),
        .q       (err_status)
    );

    sderr_summary u_sum (
        .stat    (err_status),
        .dat_tmo (flag_dat_tmo),
        .cmd_tmo (flag_cmd_tmo),
        .crc     (flag_crc),
        .endbit  (flag_endbit),
        .index   (flag_index)
    );
endmodule

// File: rtl/sderr_capture_chk.sv
module sderr_capture_chk #(
    parameter bit AUTO_STOP = 1'b1
) (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_wr,
    input logic        rsp_auto,
    input logic        ev_rsp_tmo,
    input logic        ev_rsp_idx,
    input logic        ev_busy_tmo,
    input logic [31:0] err_status,
    input logic        flag_cmd_tmo,
    input logic        flag_dat_tmo
);
    assert_fixed_bits_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (err_status & 32'hFF8C_F0C0) == 32'h0000_2000);

    assert_sticky_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_wr |=> ((err_status & $past(err_status)) == $past(err_status)));

    assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !ev_rsp_tmo && !ev_rsp_idx && !ev_busy_tmo) |=>
        (err_status[22] == 1'b0 && err_status[16] == 1'b0 && err_status[13] == 1'b1));

    assert_plain_tmo_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_rsp_tmo && !rsp_auto) |=> err_status[16]);

    assert_event_after_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && ev_busy_tmo) |=> err_status[22]);

    assert_summary_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_cmd_tmo == (err_status[17] | err_status[16])) &&
        (flag_dat_tmo == (|err_status[22:20])));

    if (AUTO_STOP) begin : g_auto_chk
        assert_auto_tmo_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (ev_rsp_tmo && rsp_auto && !cmd_wr) |=> (err_status[17] && $stable(err_status[16])));
    end else begin : g_noauto_chk
        assert_no_auto_bits_R12: assert property (@(posedge clk) disable iff (!rst_n)
            (err_status & 32'h0002_020A) == 32'h0);
    end
endmodule

bind sderr_capture sderr_capture_chk #(.AUTO_STOP(AUTO_STOP)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_wr       (cmd_wr),
    .rsp_auto     (rsp_auto),
    .ev_rsp_tmo   (ev_rsp_tmo),
    .ev_rsp_idx   (ev_rsp_idx),
    .ev_busy_tmo  (ev_busy_tmo),
    .err_status   (err_status),
    .flag_cmd_tmo (flag_cmd_tmo),
    .flag_dat_tmo (flag_dat_tmo)
);

// File: tb/sderr_capture_bench.sv
module sderr_capture_bench;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n;
    logic cmd_wr;
    // vec bit order: [11]=rsp_auto [10]=idx [9]=rsp_end [8]=rd_end [7]=wst_end
    // [6]=rsp_crc [5]=rd_crc [4]=wst_crc [3]=rsp_tmo [2]=start [1]=crcstat [0]=busy
    logic [11:0] vec;

    logic [31:0] st_a, st_b;
    logic [4:0]  fl_a, fl_b;

    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] m_a, m_b;

    sderr_capture #(.AUTO_STOP(1'b1)) u_sderr_capture (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .rsp_auto(vec[11]),
        .ev_busy_tmo(vec[0]), .ev_crcstat_tmo(vec[1]), .ev_start_tmo(vec[2]),
        .ev_rsp_tmo(vec[3]), .ev_wstat_crc(vec[4]), .ev_rdata_crc(vec[5]),
        .ev_rsp_crc(vec[6]), .ev_wstat_end(vec[7]), .ev_rdata_end(vec[8]),
        .ev_rsp_end(vec[9]), .ev_rsp_idx(vec[10]),
        .err_status(st_a), .flag_dat_tmo(fl_a[4]), .flag_cmd_tmo(fl_a[3]),
        .flag_crc(fl_a[2]), .flag_endbit(fl_a[1]), .flag_index(fl_a[0]));

    sderr_capture #(.AUTO_STOP(1'b0)) u_sderr_capture_noauto (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .rsp_auto(vec[11]),
        .ev_busy_tmo(vec[0]), .ev_crcstat_tmo(vec[1]), .ev_start_tmo(vec[2]),
        .ev_rsp_tmo(vec[3]), .ev_wstat_crc(vec[4]), .ev_rdata_crc(vec[5]),
        .ev_rsp_crc(vec[6]), .ev_wstat_end(vec[7]), .ev_rdata_end(vec[8]),
        .ev_rsp_end(vec[9]), .ev_rsp_idx(vec[10]),
        .err_status(st_b), .flag_dat_tmo(fl_b[4]), .flag_cmd_tmo(fl_b[3]),
        .flag_crc(fl_b[2]), .flag_endbit(fl_b[1]), .flag_index(fl_b[0]));

    function automatic logic [31:0] set_bits(logic [11:0] v, bit auto_en);
        logic [31:0] s = '0;
        logic a = v[11];
        s[22] = v[0]; s[21] = v[1]; s[20] = v[2];
        s[11] = v[4]; s[10] = v[5]; s[5] = v[7]; s[4] = v[8];
        s[16] = v[3] & ~a;  s[8] = v[6] & ~a;  s[2] = v[9] & ~a;  s[0] = v[10] & ~a;
        if (auto_en) begin
            s[17] = v[3] & a; s[9] = v[6] & a; s[3] = v[9] & a; s[1] = v[10] & a;
        end
        return s;
    endfunction

    function automatic logic [4:0] flags_of(logic [31:0] m);
        return {|m[22:20], |m[17:16], |m[11:8], |m[5:2], |m[1:0]};
    endfunction

    task automatic check(string tag, logic [31:0] got_s, logic [31:0] exp_s,
                         logic [4:0] got_f, logic [4:0] exp_f);
        n_chk++;
        if (got_s !== exp_s || got_f !== exp_f) begin
            n_fail++;
            $display("FAIL %s: status=%h flags=%b expected status=%h flags=%b",
                     tag, got_s, got_f, exp_s, exp_f);
        end
    endtask

    task automatic check_both(string tag);
        check(tag, st_a, m_a | 32'h2000, fl_a, flags_of(m_a));
        check({tag, " noauto"}, st_b, m_b | 32'h2000, fl_b, flags_of(m_b));
    endtask

    // Drive at the falling edge, model the rising edge, sample at the next falling edge.
    task automatic step(logic [11:0] v, logic clr, string tag);
        vec = v;
        cmd_wr = clr;
        @(posedge clk);
        m_a = (clr ? 32'h0 : m_a) | set_bits(v, 1'b1);
        m_b = (clr ? 32'h0 : m_b) | set_bits(v, 1'b0);
        @(negedge clk);
        check_both(tag);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'h5D1E_0C12));
        rst_n = 1'b0; cmd_wr = 1'b0; vec = '0;
        m_a = '0; m_b = '0;
        repeat (3) @(negedge clk);
        check_both("R2 in reset");
        check_both("R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_both("R2 after reset");

        step(12'h001, 1'b0, "R3 busy timeout");
        step(12'h002, 1'b0, "R3 crc-status timeout");
        step(12'h004, 1'b0, "R3 start timeout");
        step(12'h000, 1'b1, "R9 clear");
        step(12'h808, 1'b0, "R4 auto rsp timeout (R12 in noauto)");
        step(12'h008, 1'b0, "R4 plain rsp timeout");
        step(12'h000, 1'b1, "R9 clear");
        step(12'h030, 1'b0, "R5 data crc");
        step(12'h840, 1'b0, "R5 auto rsp crc");
        step(12'h040, 1'b0, "R5 plain rsp crc");
        step(12'h180, 1'b0, "R6 data end bit");
        step(12'hA00, 1'b0, "R6 auto rsp end (R12)");
        step(12'h200, 1'b0, "R6 plain rsp end");
        step(12'hC00, 1'b0, "R7 auto index (R12)");
        step(12'h400, 1'b0, "R7 plain index");
        for (int i = 0; i < 5; i++) step(12'h000, 1'b0, "R8 sticky hold");
        step(12'h040, 1'b1, "R10 clear with event");
        step(12'h841, 1'b1, "R10 clear with auto event");
        step(12'h000, 1'b1, "R9 clear keeps bit13");

        for (int i = 0; i < 400; i++) begin
            logic [11:0] v = '0;
            for (int b = 0; b < 11; b++) v[b] = ($urandom % 10) == 0;
            v[11] = $urandom % 2;
            step(v, ($urandom % 8) == 0, "R11 random mix");
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule